// File: doc/BRIEF.md
# Per-Channel Fault Latch Controller

This block keeps the fault state for a bank of low-side output channels (eight by default). For every channel it takes the host's on/off data bit plus two raw comparator signals, one for overcurrent and one for open load. Each comparator is filtered by a persistence window counted in system clock cycles. A condition that lasts the whole window latches a sticky flag. The flags are collected into a 16-bit fault register, which a serial shifter elsewhere reads. The block also produces the gated drive signal for each channel, and an active-low fault output.

Flags clear in three ways. A write to the data bit clears a flag, and each fault type has its own polarity: an overcurrent flag clears when the bit goes to 0, and an open-load flag clears when the bit goes to 1. A one-cycle fault-reset pulse clears every flag at once. An undervoltage input acts as a silent synchronous reset of all state. Over-temperature turns every channel off and pulls the fault output low, but it sets no register bit. A parameter can remove the open-load logic altogether.

Top module: `fault_latch_ctrl`

## Requirements
- R1: The fault register holds the overcurrent flag of channel i at bit 8+i and the open-load flag of channel i at bit i (i = 0..7).
- R2: An overcurrent flag sets only after the raw comparator has been high on 300 consecutive clock edges while the channel is driven (3000 ns at 100 MHz). If the comparator drops before then, the count restarts from zero.
- R3: Once a channel's overcurrent flag is set, its drive output stays 0 until the flag clears, even with its data bit held at 1.
- R4: An overcurrent flag clears on the first clock edge at which the channel's data bit is 0.
- R5: Open-load detection runs only while the data bit is 0. The flag sets after 1700 consecutive high edges (17000 ns), and it clears on the first edge at which the data bit is 1.
- R6: A fault-reset pulse clears all 16 bits on the next edge. The clear wins over a flag that would set on that same edge.
- R7: The fault output is 0 whenever any register bit is set, and it is 1 once all bits are clear (with no over-temperature or undervoltage present).
- R8: While over-temperature is high, every drive output is 0 and the fault output is 0, and no register bit is set. When the input drops, the drive outputs follow the data bits again.
- R9: Undervoltage forces all drive outputs to 0 and keeps the fault output at 1, even during over-temperature. It clears all register bits on the next edge.
- R10: With open-load detection disabled by parameter, bits 7..0 always read 0 and open-load conditions never pull the fault output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Undervoltage flag, silent synchronous reset |
| ot_i | input | 1 | Over-temperature flag |
| flt_clr_i | input | 1 | Fault-reset pulse, one cycle |
| data_i | input | 8 | Host on/off bit per channel |
| oc_raw_i | input | 8 | Raw overcurrent comparators |
| ol_raw_i | input | 8 | Raw open-load comparators |
| drive_o | output | 8 | Gated drive per channel |
| fault_reg_o | output | 16 | Fault register, overcurrent flags in the high byte |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The assertions take for granted that the comparator and flag inputs are clean and synchronous to the clock. They also assume the fault-reset input is a pulse that may coincide with a window expiry, and that undervoltage may arrive at any time. The stimulus changes every input only on the falling clock edge. It holds each comparator steady across whole windows, except where a restart is being tested, and then it drops the comparator for exactly one edge. It lines up the reset pulse with the exact edge on which a window completes.

// File: rtl/flc_pkg.sv
package flc_pkg;
  // Convert a time window in ns to a whole number of clock cycles (rounded up, at least 2).
  function automatic int unsigned window_cycles(input int unsigned clk_mhz, input int unsigned ns);
    int unsigned c;
    c = (clk_mhz * ns + 999) / 1000;
    if (c < 2) c = 2;
    return c;
  endfunction

  // Width of a counter that must hold values 0..n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/flc_deglitch.sv
module flc_deglitch #(
  parameter int unsigned N = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclr,
  input  logic arm,
  output logic hit
);
  localparam int unsigned CW = flc_pkg::cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign hit     = arm && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (sclr || !arm) cnt <= '0;
    else if (!at_last)   cnt <= cnt + 1'b1;
  end

  // R2
  hit_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(arm));
  // R2
  restart_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt == '0));
endmodule

// File: rtl/flc_channel.sv
module flc_channel #(
  parameter int unsigned OC_N  = 300,
  parameter int unsigned OL_N  = 1700,
  parameter bit          OL_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclr,
  input  logic clr,
  input  logic ot,
  input  logic data,
  input  logic oc_raw,
  input  logic ol_raw,
  output logic drive,
  output logic oc_flag,
  output logic ol_flag
);
  logic oc_arm, oc_hit;

  assign drive  = data && !oc_flag && !ot && !sclr;
  assign oc_arm = oc_raw && drive;

  flc_deglitch #(.N(OC_N)) u_oc_dg (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .arm(oc_arm), .hit(oc_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   oc_flag <= 1'b0;
    else if (sclr || clr || !data) oc_flag <= 1'b0;
    else if (oc_hit)              oc_flag <= 1'b1;
  end

  generate
    if (OL_EN) begin : g_ol
      logic ol_arm, ol_hit, ol_q;
      assign ol_arm = ol_raw && !data && !sclr;

      flc_deglitch #(.N(OL_N)) u_ol_dg (
        .clk(clk), .rst_n(rst_n), .sclr(sclr), .arm(ol_arm), .hit(ol_hit)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ol_q <= 1'b0;
        else if (sclr || clr || data) ol_q <= 1'b0;
        else if (ol_hit)             ol_q <= 1'b1;
      end
      assign ol_flag = ol_q;

      // R5
      ol_clear_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data |=> !ol_flag);
    end else begin : g_no_ol
      assign ol_flag = 1'b0;
    end
  endgenerate

  // R4
  oc_clear_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data |=> !oc_flag);
  // R2
  oc_set_while_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_flag) |-> $past(data));
endmodule

// File: rtl/fault_latch_ctrl.sv
module fault_latch_ctrl #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned OC_NS   = 3000,
  parameter int unsigned OL_NS   = 17000,
  parameter bit          OL_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_i,
  input  logic             ot_i,
  input  logic             flt_clr_i,
  input  logic [NCH-1:0]   data_i,
  input  logic [NCH-1:0]   oc_raw_i,
  input  logic [NCH-1:0]   ol_raw_i,
  output logic [NCH-1:0]   drive_o,
  output logic [2*NCH-1:0] fault_reg_o,
  output logic             fault_n_o
);
  localparam int unsigned OC_N = flc_pkg::window_cycles(CLK_MHZ, OC_NS);
  localparam int unsigned OL_N = flc_pkg::window_cycles(CLK_MHZ, OL_NS);

  logic [NCH-1:0] oc_flags, ol_flags;
  logic           any_flag;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    flc_channel #(.OC_N(OC_N), .OL_N(OL_N), .OL_EN(OL_EN)) u_ch (
      .clk(clk), .rst_n(rst_n), .sclr(uv_i), .clr(flt_clr_i), .ot(ot_i),
      .data(data_i[i]), .oc_raw(oc_raw_i[i]), .ol_raw(ol_raw_i[i]),
      .drive(drive_o[i]), .oc_flag(oc_flags[i]), .ol_flag(ol_flags[i])
    );
  end

  assign fault_reg_o = {oc_flags, ol_flags};
  assign any_flag    = |fault_reg_o;
  assign fault_n_o   = uv_i || !(any_flag || ot_i);

  // R6
  reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr_i |=> (fault_reg_o == '0));
  // R9
  uv_clears_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (fault_reg_o == '0));
  // R8
  ot_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |-> (drive_o == '0));
endmodule

// File: tb/fault_latch_ctrl_bench.sv
`timescale 1ns/1ps
module fault_latch_ctrl_bench;
  localparam int CLK_MHZ = 100;
  localparam int OC_W = (CLK_MHZ * 3000) / 1000;   // 300 cycles
  localparam int OL_W = (CLK_MHZ * 17000) / 1000;  // 1700 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ot = 1'b0, clr = 1'b0;
  logic [7:0] data = 8'h00, oc_raw = 8'h00, ol_raw = 8'h00;
  logic [7:0] drive, drive2;
  logic [15:0] freg, freg2;
  logic fn, fn2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fault_latch_ctrl u_fault_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ot_i(ot), .flt_clr_i(clr),
    .data_i(data), .oc_raw_i(oc_raw), .ol_raw_i(ol_raw),
    .drive_o(drive), .fault_reg_o(freg), .fault_n_o(fn)
  );

  fault_latch_ctrl #(.OL_EN(1'b0)) u_nool (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ot_i(ot), .flt_clr_i(clr),
    .data_i(data), .oc_raw_i(oc_raw), .ol_raw_i(ol_raw),
    .drive_o(drive2), .fault_reg_o(freg2), .fault_n_o(fn2)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk(freg == 16'h0, "R1 reset register", freg, 0);
    chk(fn == 1'b1, "R7 reset fault_n", fn, 1);
    chk(drive == 8'h00, "R8 reset drive", drive, 0);
  endtask

  task automatic t_oc_window;
    data = 8'hFF; oc_raw[2] = 1'b1;
    waitc(150);
    oc_raw[2] = 1'b0; waitc(1);
    oc_raw[2] = 1'b1;
    waitc(OC_W - 1);
    chk(freg == 16'h0, "R2 restart after drop", freg, 0);
    waitc(1);
    chk(freg == 16'h0400, "R1 R2 oc flag position", freg, 16'h0400);
    chk(drive == 8'hFB, "R3 channel forced off", drive, 8'hFB);
    chk(fn == 1'b0, "R7 fault_n low on flag", fn, 0);
    oc_raw[2] = 1'b0; waitc(5);
    chk(drive == 8'hFB, "R3 stays off with data high", drive, 8'hFB);
    data[2] = 1'b0; waitc(1);
    chk(freg == 16'h0, "R4 oc cleared by data low", freg, 0);
    chk(fn == 1'b1, "R7 fault_n released", fn, 1);
    data[2] = 1'b1; #1;
    chk(drive == 8'hFF, "R3 drive returns", drive, 8'hFF);
  endtask

  task automatic t_ol;
    data = 8'hDF; ol_raw = 8'h60;
    waitc(OL_W - 1);
    chk(freg == 16'h0, "R5 ol before window", freg, 0);
    waitc(1);
    chk(freg == 16'h0020, "R1 R5 ol flag position", freg, 16'h0020);
    chk(fn == 1'b0, "R7 fault_n on ol", fn, 0);
    chk(freg2 == 16'h0, "R10 no ol register bits", freg2, 0);
    chk(fn2 == 1'b1, "R10 no ol fault_n", fn2, 1);
    waitc(400);
    chk(freg == 16'h0020, "R5 no detect with data high", freg, 16'h0020);
    data = 8'hFF; waitc(1);
    chk(freg == 16'h0, "R5 ol cleared by data high", freg, 0);
    ol_raw = 8'h00;
  endtask

  task automatic t_reset_cmd;
    data = 8'hFE; oc_raw = 8'h02; ol_raw = 8'h01;
    waitc(OL_W);
    chk(freg == 16'h0201, "R6 both flags set", freg, 16'h0201);
    oc_raw = 8'h00; ol_raw = 8'h00;
    clr = 1'b1; waitc(1); clr = 1'b0;
    chk(freg == 16'h0, "R6 reset clears all", freg, 0);
    waitc(5);
    chk(freg == 16'h0, "R6 stays clear", freg, 0);
    data = 8'hFF; oc_raw[3] = 1'b1;
    waitc(OC_W - 1);
    clr = 1'b1; waitc(1); clr = 1'b0;
    chk(freg == 16'h0, "R6 clear wins over set", freg, 0);
    waitc(1);
    chk(freg == 16'h0800, "R6 persisting condition relatches", freg, 16'h0800);
    data[3] = 1'b0; oc_raw = 8'h00; waitc(1);
    data = 8'hFF; #1;
  endtask

  task automatic t_ot;
    ot = 1'b1; #1;
    chk(drive == 8'h00, "R8 ot outputs off", drive, 0);
    chk(fn == 1'b0, "R8 ot fault_n low", fn, 0);
    waitc(3);
    chk(freg == 16'h0, "R8 ot sets no bit", freg, 0);
    ot = 1'b0; #1;
    chk(drive == 8'hFF, "R8 recovery", drive, 8'hFF);
    chk(fn == 1'b1, "R8 fault_n released", fn, 1);
  endtask

  task automatic t_uv;
    oc_raw[4] = 1'b1; waitc(OC_W);
    chk(freg == 16'h1000, "R9 flag before uv", freg, 16'h1000);
    oc_raw[4] = 1'b0;
    uv = 1'b1; ot = 1'b1; #1;
    chk(fn == 1'b1, "R9 fault_n silent", fn, 1);
    chk(drive == 8'h00, "R9 outputs off", drive, 0);
    waitc(1);
    chk(freg == 16'h0, "R9 register cleared", freg, 0);
    uv = 1'b0; ot = 1'b0; waitc(1);
    chk(freg == 16'h0, "R9 clear after uv", freg, 0);
    chk(drive == 8'hFF, "R9 drive resumes", drive, 8'hFF);
  endtask

  initial begin
    waitc(3);
    t_reset;
    rst_n = 1'b1;
    waitc(2);
    t_reset;
    t_oc_window;
    t_ol;
    t_reset_cmd;
    t_ot;
    t_uv;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule